// File: doc/BRIEF.md
# Instruction Fetch Address Sequencer

This block produces the program-memory fetch address for a small microcontroller core whose pipeline has two stages: while one instruction is decoded and executed, the following word is already being fetched. The system clock is divided into four one-hot phase strobes, and four phases together make one instruction cycle. The 12-bit program counter addresses a 4096 x 15-bit program store. It advances once per instruction cycle, at the end of the last phase.

The execute stage requests control transfers through strobe-and-address ports. These are jump or call with a target, return or return-from-interrupt with a popped address, interrupt entry with a vector, a write to the low counter byte that makes a short in-page jump, and a conditional skip whose condition is true. Each of these throws away the word that is already prefetched. The block raises a flush flag for the next instruction cycle, so that the execute stage treats that word as a no-operation. An instruction that changes the flow therefore costs two instruction cycles. Requests are only honoured during the last phase of a cycle, and they are ignored while a flush cycle is executing, because that slot holds no real instruction. The low counter byte can be read back on its own port.

Top module: `pc_sequencer`

## Requirements
- R1: `phase_o` is one-hot at all times after reset. The active bit moves from bit i to bit i+1 on every clock, and from bit 3 back to bit 0, so one instruction cycle is four clocks long.
- R2: A clock edge with `rst_n` low, in any phase, sets `phase_o` to 4'b0001, `fetch_addr_o` to 12'h000 and `flush_o` to 1.
- R3: `fetch_addr_o` and `flush_o` change only on the clock edge that ends a cycle, which is the edge taken while `phase_o[3]` is 1.
- R4: With no request, at the end of a cycle the address increments by one, wrapping from 12'hFFF to 12'h000, and `flush_o` becomes 0.
- R5: With `jmp_req` set, the address loads `jmp_tgt` and `flush_o` becomes 1.
- R6: With `ret_req` set, the address loads `ret_addr` and `flush_o` becomes 1.
- R7: With `irq_req` set, the address loads `irq_vec` and `flush_o` becomes 1.
- R8: With `pcl_wr` set, bits 7:0 of the address take `pcl_data`, bits 11:8 keep their value, and `flush_o` becomes 1.
- R9: With `skip_req` set, the address increments by one and `flush_o` becomes 1.
- R10: At the end of a cycle that began with `flush_o` = 1, every request is ignored. The address increments by one and `flush_o` becomes 0.
- R11: When several requests are set together, only one is served. The order of precedence is `irq_req`, then `ret_req`, then `jmp_req`, then `pcl_wr`, then `skip_req`.
- R12: A request that is asserted only in phases 0 to 2 and dropped before phase 3 has no effect.
- R13: `pcl_rd_o` always equals bits 7:0 of `fetch_addr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| jmp_req | input | 1 | Jump or call request |
| jmp_tgt | input | 12 | Jump or call target |
| ret_req | input | 1 | Return or return-from-interrupt request |
| ret_addr | input | 12 | Popped return address |
| irq_req | input | 1 | Interrupt entry request (internal or external) |
| irq_vec | input | 12 | Interrupt vector address |
| pcl_wr | input | 1 | Write strobe for the low counter byte |
| pcl_data | input | 8 | New low byte |
| skip_req | input | 1 | Conditional skip with a true condition |
| phase_o | output | 4 | One-hot phase strobes |
| fetch_addr_o | output | 12 | Program memory fetch address |
| flush_o | output | 1 | The current execute slot is a dummy cycle |
| pcl_rd_o | output | 8 | Read-back of the low counter byte |

## Verification
The main function is driven through a sequence of single requests of each kind. The sequence includes a skip, which is the only case that both increments and flushes, and an in-page write, which must keep the page bits while a jump does not. It also includes a jump to the top address followed by a plain cycle, which tests the wrap. Requests placed in the cycle straight after a flush show that the dummy slot cannot redirect. Stacked requests, removed one at a time, confirm each step of the precedence order. A pulse that is dropped before the last phase shows that sampling happens only at the cycle boundary, and a reset in mid-cycle shows that the phase counter is forced back to its start.

// File: rtl/pcs_pkg.sv
// Package: shared types for the fetch address sequencer.
// Assumes a single source of the next address is chosen per instruction cycle.
package pcs_pkg;
    // Source of the next fetch address, lowest precedence first
    typedef enum logic [2:0] {
        SRC_SEQ  = 3'd0,
        SRC_SKIP = 3'd1,
        SRC_PCL  = 3'd2,
        SRC_JMP  = 3'd3,
        SRC_RET  = 3'd4,
        SRC_IRQ  = 3'd5
    } src_e;
endpackage

// File: rtl/pcs_phase_gen.sv
// Module: pcs_phase_gen
// Divides the system clock into PHASES one-hot strobes and flags the last one.
// Assumes a synchronous active-low reset that returns the counter to phase 0.
module pcs_phase_gen #(
    parameter int PHASES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [PHASES-1:0] phase,
    output logic              cyc_end
);
    localparam int PH_W = (PHASES > 1) ? $clog2(PHASES) : 1;
    localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);

    logic [PH_W-1:0] cnt;

    // Advance the phase counter, wrapping after the last phase
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + PH_W'(1);
    end

    // Decode one strobe per phase
    for (genvar i = 0; i < PHASES; i++) begin : g_strobe
        assign phase[i] = (cnt == PH_W'(i));
    end

    assign cyc_end = (cnt == LAST);
endmodule

// File: rtl/pcs_next_sel.sv
// Module: pcs_next_sel
// Chooses the next fetch address from the pending requests by fixed precedence.
// Assumes the caller applies the result only at a cycle end outside a flush cycle.
module pcs_next_sel
    import pcs_pkg::*;
#(
    parameter int PC_W   = 12,
    parameter int PAGE_W = 8
) (
    input  logic [PC_W-1:0]   pc,
    input  logic              irq_req,
    input  logic [PC_W-1:0]   irq_vec,
    input  logic              ret_req,
    input  logic [PC_W-1:0]   ret_addr,
    input  logic              jmp_req,
    input  logic [PC_W-1:0]   jmp_tgt,
    input  logic              pcl_wr,
    input  logic [PAGE_W-1:0] pcl_data,
    input  logic              skip_req,
    output src_e              src,
    output logic [PC_W-1:0]   next_pc
);
    logic [PC_W-1:0] pc_inc;
    logic [PC_W-1:0] pc_page;

    assign pc_inc  = pc + PC_W'(1);
    assign pc_page = {pc[PC_W-1:PAGE_W], pcl_data};

    // Pick the winning request, highest precedence first
    always_comb begin
        if (irq_req)       src = SRC_IRQ;
        else if (ret_req)  src = SRC_RET;
        else if (jmp_req)  src = SRC_JMP;
        else if (pcl_wr)   src = SRC_PCL;
        else if (skip_req) src = SRC_SKIP;
        else               src = SRC_SEQ;
    end

    // Form the address that belongs to the chosen source
    always_comb begin
        unique case (src)
            SRC_IRQ: next_pc = irq_vec;
            SRC_RET: next_pc = ret_addr;
            SRC_JMP: next_pc = jmp_tgt;
            SRC_PCL: next_pc = pc_page;
            default: next_pc = pc_inc;
        endcase
    end
endmodule

// File: rtl/pc_sequencer.sv
// Module: pc_sequencer (top)
// Holds the program counter and the dummy-cycle flag of a two-stage fetch/execute
// pipeline. Updates once per instruction cycle, at the end of its last phase.
// Assumes the execute stage holds its requests stable through the last phase.
module pc_sequencer
    import pcs_pkg::*;
#(
    parameter int PC_W   = 12,
    parameter int PAGE_W = 8,
    parameter int PHASES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              jmp_req,
    input  logic [PC_W-1:0]   jmp_tgt,
    input  logic              ret_req,
    input  logic [PC_W-1:0]   ret_addr,
    input  logic              irq_req,
    input  logic [PC_W-1:0]   irq_vec,
    input  logic              pcl_wr,
    input  logic [PAGE_W-1:0] pcl_data,
    input  logic              skip_req,
    output logic [PHASES-1:0] phase_o,
    output logic [PC_W-1:0]   fetch_addr_o,
    output logic              flush_o,
    output logic [PAGE_W-1:0] pcl_rd_o
);
    logic            cyc_end;
    logic [PC_W-1:0] pc_q;
    logic            flush_q;
    logic [PC_W-1:0] next_pc;
    src_e            src;

    pcs_phase_gen #(.PHASES(PHASES)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase   (phase_o),
        .cyc_end (cyc_end)
    );

    pcs_next_sel #(.PC_W(PC_W), .PAGE_W(PAGE_W)) u_sel (
        .pc       (pc_q),
        .irq_req  (irq_req),
        .irq_vec  (irq_vec),
        .ret_req  (ret_req),
        .ret_addr (ret_addr),
        .jmp_req  (jmp_req),
        .jmp_tgt  (jmp_tgt),
        .pcl_wr   (pcl_wr),
        .pcl_data (pcl_data),
        .skip_req (skip_req),
        .src      (src),
        .next_pc  (next_pc)
    );

    // Update the counter and dummy-cycle flag at each instruction cycle boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= '0;
            flush_q <= 1'b1;
        end else if (cyc_end) begin
            if (flush_q) begin
                pc_q    <= pc_q + PC_W'(1);
                flush_q <= 1'b0;
            end else begin
                pc_q    <= next_pc;
                flush_q <= (src != SRC_SEQ);
            end
        end
    end

    assign fetch_addr_o = pc_q;
    assign flush_o      = flush_q;
    assign pcl_rd_o     = pc_q[PAGE_W-1:0];
endmodule

// File: rtl/pcs_checker.sv
// Module: pcs_checker
// Property checks on the ports of pc_sequencer; attached by the bind below.
// Assumes the phase strobe width equals PHASES and phase PHASES-1 ends the cycle.
module pcs_checker #(
    parameter int PC_W   = 12,
    parameter int PAGE_W = 8,
    parameter int PHASES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              jmp_req,
    input logic [PC_W-1:0]   jmp_tgt,
    input logic              ret_req,
    input logic              irq_req,
    input logic [PC_W-1:0]   irq_vec,
    input logic              pcl_wr,
    input logic              skip_req,
    input logic [PHASES-1:0] phase_o,
    input logic [PC_W-1:0]   fetch_addr_o,
    input logic              flush_o
);
    logic last;
    assign last = phase_o[PHASES-1];

    p_phase_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phase_o) == 1);

    p_phase_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> phase_o[0]);

    p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !last |=> ($stable(fetch_addr_o) && $stable(flush_o)));

    p_flush_ignores_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (last && flush_o) |=>
            (!flush_o && fetch_addr_o == PC_W'($past(fetch_addr_o) + PC_W'(1))));

    p_irq_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !flush_o && irq_req) |=> (flush_o && fetch_addr_o == $past(irq_vec)));

    p_jump_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !flush_o && jmp_req && !irq_req && !ret_req) |=>
            (flush_o && fetch_addr_o == $past(jmp_tgt)));

    p_page_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !flush_o && pcl_wr && !irq_req && !ret_req && !jmp_req) |=>
            (flush_o && fetch_addr_o[PC_W-1:PAGE_W] == $past(fetch_addr_o[PC_W-1:PAGE_W])));

    p_skip_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !flush_o && skip_req && !irq_req && !ret_req && !jmp_req && !pcl_wr) |=>
            (flush_o && fetch_addr_o == PC_W'($past(fetch_addr_o) + PC_W'(1))));
endmodule

bind pc_sequencer pcs_checker #(.PC_W(PC_W), .PAGE_W(PAGE_W), .PHASES(PHASES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .jmp_req      (jmp_req),
    .jmp_tgt      (jmp_tgt),
    .ret_req      (ret_req),
    .irq_req      (irq_req),
    .irq_vec      (irq_vec),
    .pcl_wr       (pcl_wr),
    .skip_req     (skip_req),
    .phase_o      (phase_o),
    .fetch_addr_o (fetch_addr_o),
    .flush_o      (flush_o)
);

// File: tb/pc_sequencer_tb.sv
`timescale 1ns/1ps
// Bench for pc_sequencer: a vector table walked by one loop, then directed tests.
module pc_sequencer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        jmp_req = 1'b0, ret_req = 1'b0, irq_req = 1'b0, pcl_wr = 1'b0, skip_req = 1'b0;
    logic [11:0] jmp_tgt = '0, ret_addr = '0, irq_vec = '0;
    logic [7:0]  pcl_data = '0;
    logic [3:0]  phase_o;
    logic [11:0] fetch_addr_o;
    logic        flush_o;
    logic [7:0]  pcl_rd_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    pc_sequencer u_dut (
        .clk(clk), .rst_n(rst_n),
        .jmp_req(jmp_req), .jmp_tgt(jmp_tgt),
        .ret_req(ret_req), .ret_addr(ret_addr),
        .irq_req(irq_req), .irq_vec(irq_vec),
        .pcl_wr(pcl_wr), .pcl_data(pcl_data),
        .skip_req(skip_req),
        .phase_o(phase_o), .fetch_addr_o(fetch_addr_o),
        .flush_o(flush_o), .pcl_rd_o(pcl_rd_o)
    );

    // Request mask bit order: {irq, ret, jmp, pcl, skip}
    typedef struct packed {
        logic [4:0]  mask;
        logic [11:0] tgt;
        logic [11:0] exp_addr;
        logic        exp_flush;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{5'b00000, 12'h000, 12'h001, 1'b0},  // R10 first cycle after reset is a flush
        '{5'b00000, 12'h000, 12'h002, 1'b0},  // R4
        '{5'b00100, 12'h345, 12'h345, 1'b1},  // R5
        '{5'b00100, 12'h700, 12'h346, 1'b0},  // R10 jump in dummy slot ignored
        '{5'b00000, 12'h000, 12'h347, 1'b0},  // R4
        '{5'b00001, 12'h000, 12'h348, 1'b1},  // R9
        '{5'b00000, 12'h000, 12'h349, 1'b0},  // R10
        '{5'b00010, 12'h010, 12'h310, 1'b1},  // R8
        '{5'b00000, 12'h000, 12'h311, 1'b0},  // R4
        '{5'b01000, 12'hABC, 12'hABC, 1'b1},  // R6
        '{5'b00000, 12'h000, 12'hABD, 1'b0},  // R4
        '{5'b10000, 12'h004, 12'h004, 1'b1},  // R7
        '{5'b00000, 12'h000, 12'h005, 1'b0},  // R4
        '{5'b00010, 12'h0FF, 12'h0FF, 1'b1},  // R8
        '{5'b00000, 12'h000, 12'h100, 1'b0},  // R4 crosses page
        '{5'b00100, 12'hFFF, 12'hFFF, 1'b1},  // R5
        '{5'b00000, 12'h000, 12'h000, 1'b0}   // R4 wrap
    };

    function automatic string tag_of(input logic [4:0] m);
        if (m[4])      return "R7";
        else if (m[3]) return "R6";
        else if (m[2]) return "R5";
        else if (m[1]) return "R8";
        else if (m[0]) return "R9";
        else           return "R4";
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive requests at a cycle start (negedge, phase 0), run one instruction cycle
    task automatic instr(input logic [4:0] m, input logic [11:0] iv, input logic [11:0] rv,
                         input logic [11:0] jv, input logic [7:0] pv);
        {irq_req, ret_req, jmp_req, pcl_wr, skip_req} = m;
        irq_vec = iv; ret_addr = rv; jmp_tgt = jv; pcl_data = pv;
        repeat (4) @(posedge clk);
        @(negedge clk);
        {irq_req, ret_req, jmp_req, pcl_wr, skip_req} = '0;
    endtask

    task automatic expect_out(input string tag, input logic [11:0] a, input logic f);
        check(tag, 32'(fetch_addr_o), 32'(a));
        check(tag, 32'(flush_o), 32'(f));
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R2 reset state
        check("R2", 32'(phase_o), 32'h1);
        expect_out("R2", 12'h000, 1'b1);
        rst_n = 1'b1;

        foreach (VEC[i]) begin
            instr(VEC[i].mask, VEC[i].tgt, VEC[i].tgt, VEC[i].tgt, VEC[i].tgt[7:0]);
            expect_out((i == 0 || i == 3 || i == 6) ? "R10" : tag_of(VEC[i].mask),
                       VEC[i].exp_addr, VEC[i].exp_flush);
        end

        // R11 precedence, removing the winner step by step
        instr(5'b11111, 12'h008, 12'h333, 12'h222, 8'h55);
        expect_out("R11", 12'h008, 1'b1);
        instr(5'b00000, '0, '0, '0, '0);
        instr(5'b01111, 12'h008, 12'h333, 12'h222, 8'h55);
        expect_out("R11", 12'h333, 1'b1);
        instr(5'b00000, '0, '0, '0, '0);
        instr(5'b00111, 12'h008, 12'h333, 12'h222, 8'h55);
        expect_out("R11", 12'h222, 1'b1);
        instr(5'b00000, '0, '0, '0, '0);
        instr(5'b00011, 12'h008, 12'h333, 12'h222, 8'h55);
        expect_out("R11", 12'h255, 1'b1);
        instr(5'b00000, '0, '0, '0, '0);
        expect_out("R10", 12'h256, 1'b0);

        // R12 pulse dropped before the last phase; R1 and R3 checked through the cycle
        jmp_req = 1'b1; jmp_tgt = 12'h777;
        for (int p = 0; p < 4; p++) begin
            check("R1", 32'(phase_o), 32'(4'b0001 << p));
            check("R3", 32'(fetch_addr_o), 32'h256);
            @(posedge clk);
            @(negedge clk);
            jmp_req = 1'b0;
        end
        expect_out("R12", 12'h257, 1'b0);
        check("R1", 32'(phase_o), 32'h1);
        check("R13", 32'(pcl_rd_o), 32'h57);

        // R2 reset in mid-cycle
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R2", 32'(phase_o), 32'h1);
        expect_out("R2", 12'h000, 1'b1);
        check("R13", 32'(pcl_rd_o), 32'h00);
        instr(5'b10100, 12'h0AA, 12'h000, 12'h0BB, 8'h00);
        expect_out("R10", 12'h001, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule